// File: doc/BRIEF.md
# Universal Shift Register with J/K-bar Serial Entry

This block is a clocked register of `STAGES` bits (four by default) that either loads all stages in parallel or shifts its contents one place on each rising clock edge. In shift mode the first stage gets its next value from a J / K-bar input pair rather than from a plain serial input. The remaining stages form a D flip-flop chain, and each of them copies the stage before it.

The outputs show either the stored bits or their inverse. A true/complement select chooses between the two. This select is purely combinational and does not depend on the clock. An active-high reset clears every stage at once, without waiting for a clock edge. With the J and K-bar inputs tied together, the first stage acts as a D flip-flop. Feeding the inverted last stage back into that pair turns the register into a Johnson counter.

Top module: `jkb_shift_register`

## Requirements
- R1: While `rst` is high, every stage holds 0 with no clock edge needed. `q_out` then reads all zeros when `true_out` is 1 and all ones when `true_out` is 0.
- R2: On a rising edge with `load_par` = 1 and `rst` low, stage k (bit k-1 of the state) takes `par_d[k-1]`.
- R3: On a rising edge with `load_par` = 0 and `rst` low, every stage from bit 1 upward takes the value that the bit below it held before the edge.
- R4: In shift mode, bit 0 is set by the pair `{j_in, kb_in}` as follows: 00 clears it, 11 sets it, 01 keeps it, and 10 inverts it.
- R5: When `j_in` equals `kb_in` in shift mode, bit 0 takes that common value, as a D flip-flop would.
- R6: `q_out` equals the state when `true_out` = 1 and the bitwise inverse of the state when `true_out` = 0. It follows `true_out` with no clock edge.
- R7: Reset wins over both load and shift. A rising edge while `rst` is high leaves the state at zero, whatever `load_par`, `par_d`, `j_in` and `kb_in` are.
- R8: `load_par` is sampled only at the rising edge. A change of `load_par` between edges does not alter `q_out` before the next edge, and only the value present at the edge selects the operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous reset, active high |
| load_par | input | 1 | 1 = parallel load, 0 = shift |
| j_in | input | 1 | J input of the first stage |
| kb_in | input | 1 | K-bar input of the first stage |
| par_d | input | STAGES | Parallel data; bit k-1 is the data for stage k |
| true_out | input | 1 | 1 = true outputs, 0 = complemented outputs |
| q_out | output | STAGES | Register outputs after polarity selection |

## Verification
The bench sweeps every parallel value under both output polarities and every J/K-bar pair from both starting values of the first stage. If the set and hold encodings were swapped, or the toggle were built as a clear, the first stage would diverge from the model within one edge. The bench runs the register as a Johnson counter and as a toggle source. A shift chain that skipped a stage, or that took bit 0 in its post-edge form, would break the eight-state cycle. Reset is raised and the mode select is changed partway through a clock period. A design with a synchronous reset, or with a mode select that acts between edges, would show a nonzero state or a changed output before the next edge. The polarity select is also flipped between edges, and a registered polarity path would lag by one cycle.

// File: rtl/jkb_sr_pkg.sv
package jkb_sr_pkg;

  // Operation selected by load_par at a clock edge
  localparam logic OP_SHIFT = 1'b0;
  localparam logic OP_LOAD  = 1'b1;

  // Next value of the first stage from the J / K-bar pair
  function automatic logic jk_next(input logic j, input logic kb, input logic q);
    return (j & ~q) | (kb & q);
  endfunction

  // Output polarity: true_sel = 1 passes the bits, 0 inverts them
  function automatic logic polar(input logic true_sel, input logic bit_v);
    return true_sel ? bit_v : ~bit_v;
  endfunction

endpackage

// File: rtl/jkb_head_stage.sv
module jkb_head_stage
  import jkb_sr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic armed,
  input  logic load_par,
  input  logic par_bit,
  input  logic j_in,
  input  logic kb_in,
  output logic q
);

  logic serial_next;
  assign serial_next = jk_next(j_in, kb_in, q);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                   q <= 1'b0;
    else if (load_par == OP_LOAD) q <= par_bit;
    else                       q <= serial_next;
  end

  // Named decode of the J / K-bar pair for the checks below
  logic jk_tied, jk_toggle, jk_hold;
  assign jk_tied   = (j_in == kb_in);
  assign jk_toggle = j_in & ~kb_in;
  assign jk_hold   = ~j_in & kb_in;

  p_tied_d_r5: assert property (@(posedge clk) disable iff (rst)
    armed && $past(!load_par && jk_tied) |-> q == $past(j_in));

  p_toggle_r4: assert property (@(posedge clk) disable iff (rst)
    armed && $past(!load_par && jk_toggle) |-> q != $past(q));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    armed && $past(!load_par && jk_hold) |-> $stable(q));

endmodule

// File: rtl/jkb_tail_chain.sv
module jkb_tail_chain
  import jkb_sr_pkg::*;
#(
  parameter int STAGES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              armed,
  input  logic              load_par,
  input  logic              head_q,
  input  logic [STAGES-1:1] par_tail,
  output logic [STAGES-1:1] tail_q
);

  // Full view of the register: head at bit 0, chain above it
  logic [STAGES-1:0] full_q;
  assign full_q = {tail_q, head_q};

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or posedge rst) begin
      if (rst)                   tail_q[g] <= 1'b0;
      else if (load_par == OP_LOAD) tail_q[g] <= par_tail[g];
      else                       tail_q[g] <= full_q[g-1];
    end
  end

  p_shift_r3: assert property (@(posedge clk) disable iff (rst)
    armed && $past(!load_par) |-> tail_q == $past(full_q[STAGES-2:0]));

endmodule

// File: rtl/jkb_out_polarity.sv
module jkb_out_polarity
  import jkb_sr_pkg::*;
#(
  parameter int STAGES = 4
) (
  input  logic              true_out,
  input  logic [STAGES-1:0] state,
  output logic [STAGES-1:0] q_out
);

  for (genvar g = 0; g < STAGES; g++) begin : g_pol
    assign q_out[g] = polar(true_out, state[g]);
  end

endmodule

// File: rtl/jkb_shift_register.sv
module jkb_shift_register
  import jkb_sr_pkg::*;
#(
  parameter int STAGES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_par,
  input  logic              j_in,
  input  logic              kb_in,
  input  logic [STAGES-1:0] par_d,
  input  logic              true_out,
  output logic [STAGES-1:0] q_out
);

  logic              head_q;
  logic [STAGES-1:1] tail_q;
  logic [STAGES-1:0] state;
  assign state = {tail_q, head_q};

  // Set once an edge has passed out of reset; lets the checks trust $past
  logic armed;
  always_ff @(posedge clk or posedge rst) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  jkb_head_stage u_head (
    .clk      (clk),
    .rst      (rst),
    .armed    (armed),
    .load_par (load_par),
    .par_bit  (par_d[0]),
    .j_in     (j_in),
    .kb_in    (kb_in),
    .q        (head_q)
  );

  jkb_tail_chain #(.STAGES(STAGES)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .armed    (armed),
    .load_par (load_par),
    .head_q   (head_q),
    .par_tail (par_d[STAGES-1:1]),
    .tail_q   (tail_q)
  );

  jkb_out_polarity #(.STAGES(STAGES)) u_pol (
    .true_out (true_out),
    .state    (state),
    .q_out    (q_out)
  );

  p_reset_r1: assert property (@(posedge clk) rst |-> state == '0);

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    armed && $past(load_par) |-> state == $past(par_d));

  p_polarity_r6: assert property (@(posedge clk)
    (q_out ^ state) == {STAGES{!true_out}});

endmodule

// File: tb/jkb_shift_register_bench.sv
module jkb_shift_register_bench;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst, load_par, j_in, kb_in, true_out;
  logic [N-1:0] par_d;
  logic [N-1:0] q_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [N-1:0] m = '0;

  always #4 clk = ~clk;

  jkb_shift_register #(.STAGES(N)) u_jkb_shift_register (
    .clk(clk), .rst(rst), .load_par(load_par), .j_in(j_in), .kb_in(kb_in),
    .par_d(par_d), .true_out(true_out), .q_out(q_out)
  );

  function automatic logic [N-1:0] expect_out(input logic [N-1:0] st, input logic t);
    return t ? st : (st ^ {N{1'b1}});
  endfunction

  task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  // Model of one clock edge, written as a truth table
  task automatic model_edge(input logic ld, input logic j, input logic kb, input logic [N-1:0] d);
    logic h;
    if (ld) m = d;
    else begin
      case ({j, kb})
        2'b00:   h = 1'b0;
        2'b11:   h = 1'b1;
        2'b01:   h = m[0];
        default: h = ~m[0];
      endcase
      m = {m[N-2:0], h};
    end
  endtask

  task automatic step(input string req, input logic ld, input logic j, input logic kb,
                      input logic [N-1:0] d);
    load_par = ld; j_in = j; kb_in = kb; par_d = d;
    @(posedge clk);
    model_edge(ld, j, kb, d);
    #1;
    check(req, q_out, expect_out(m, true_out));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; load_par = 1'b0; j_in = 1'b0; kb_in = 1'b0; par_d = '0; true_out = 1'b1;
    #3;
    check("R1 reset true", q_out, '0);
    true_out = 1'b0; #1;
    check("R1 reset complement", q_out, '1);
    true_out = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;

    // R2 / R6: every parallel value in both polarities
    for (int t = 0; t < 2; t++) begin
      true_out = t[0];
      for (int v = 0; v < (1 << N); v++) step("R2 parallel load", 1'b1, 1'b0, 1'b0, v[N-1:0]);
    end
    true_out = 1'b1;

    // R4: every J/K-bar pair from both starting values of bit 0
    for (int s = 0; s < 2; s++) begin
      for (int p = 0; p < 4; p++) begin
        step("R4 preload", 1'b1, 1'b0, 1'b0, {3'b101, s[0]});
        step("R4 jk pair", 1'b0, p[1], p[0], '0);
      end
    end

    // R5 / R3: Johnson counter with J = K-bar = inverted last stage
    step("R2 clear", 1'b1, 1'b0, 1'b0, '0);
    for (int i = 0; i < 12; i++) step("R5 R3 johnson", 1'b0, ~m[N-1], ~m[N-1], '0);

    // R4 / R3: toggle pattern
    step("R2 clear", 1'b1, 1'b0, 1'b0, '0);
    for (int i = 0; i < 10; i++) step("R4 R3 toggle", 1'b0, 1'b1, 1'b0, 4'b1111);

    // R6: polarity switched between edges
    step("R2 load", 1'b1, 1'b0, 1'b0, 4'b1001);
    true_out = 1'b0; #1;
    check("R6 async complement", q_out, 4'b0110);
    true_out = 1'b1; #1;
    check("R6 async true", q_out, 4'b1001);

    // R8: mode pulsed high between edges, low again at the edge
    load_par = 1'b1; par_d = 4'b0110; #1;
    check("R8 no change between edges", q_out, expect_out(m, true_out));
    load_par = 1'b0; j_in = 1'b1; kb_in = 1'b1;
    @(posedge clk); model_edge(1'b0, 1'b1, 1'b1, 4'b0110); #1;
    check("R8 shift taken at edge", q_out, expect_out(m, true_out));
    load_par = 1'b0; #1;
    load_par = 1'b1; par_d = 4'b1100;
    @(posedge clk); model_edge(1'b1, 1'b0, 1'b0, 4'b1100); #1;
    check("R8 load taken at edge", q_out, expect_out(m, true_out));

    // R1 / R7: reset raised mid-period, then an edge with load requested
    step("R2 load", 1'b1, 1'b0, 1'b0, 4'b1111);
    #2; rst = 1'b1; #1;
    check("R1 mid-period reset", q_out, '0);
    true_out = 1'b0; #1;
    check("R1 reset complement", q_out, '1);
    true_out = 1'b1; load_par = 1'b1; par_d = 4'b1011; j_in = 1'b1; kb_in = 1'b1;
    @(posedge clk); #1;
    check("R7 reset beats load", q_out, '0);
    load_par = 1'b0;
    @(posedge clk); #1;
    check("R7 reset beats shift", q_out, '0);
    rst = 1'b0; m = '0;
    step("R5 after reset", 1'b0, 1'b1, 1'b1, '0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule